// File: doc/BRIEF.md
# Shared-Bus Arbiter with Split and Retry Handling

This block decides which of up to four masters owns the address phase of a pipelined shared bus. Each master raises its own request line and receives its own grant line. The block also drives an encoded index of the current address-phase owner, which steers the address and control multiplexer. Ownership follows the grant one ready-qualified edge later, so the granted master drives the bus on the cycle after the grant has been sampled with ready high.

The policy is fixed priority, with master 0 the highest. A defined-length burst keeps the grant until its second-to-last address is sampled. The grant then moves, and the next owner takes the bus directly after the last address, with no dead cycle. A slave may answer a transfer with the two-cycle RETRY or SPLIT response. A retried master keeps competing at its normal priority. A split master is masked out of arbitration until the slave sets that master's bit in the release vector.

Control is a four-state machine:
- ST_OPEN: owner and grant agree, and the block arbitrates on every ready edge.
- ST_MOVE: the grant has moved and the block waits for the owner to follow.
- ST_BURST: a fixed-length burst holds the grant.
- ST_RESP: the first, ready-low cycle of a RETRY or SPLIT has been seen.

Transitions:
- ST_OPEN → ST_BURST on the first beat of a fixed burst.
- ST_OPEN or ST_BURST → ST_MOVE when arbitration picks a new master.
- ST_MOVE → ST_OPEN on the next ready edge.
- Any state except ST_RESP → ST_RESP when ready is low with a RETRY or SPLIT code.
- ST_RESP → ST_OPEN or ST_MOVE on the ready-high second cycle.

Top module: `shbus_arbiter`

## Requirements
- R1: Among eligible requesting masters, the lowest index wins. At most one grant bit is ever set.
- R2: If no eligible master requests, the grant parks on master 0. If master 0 is split-masked, it parks on the lowest-index unmasked master.
- R3: While ready is low, the grant and the owner index hold their values.
- R4: On each ready-high edge, the owner index takes the index of the master granted before that edge. While in ST_OPEN, the grant bit of the owner is set.
- R5: Transfer kinds are encoded as 0 idle, 1 busy, 2 first beat, 3 sequential. Burst kinds are encoded as 0 single, 1 unspecified incrementing, and 2/3 four-beat, 4/5 eight-beat, 6/7 sixteen-beat. For a fixed burst of L beats, the grant holds through beat L-2 and is re-arbitrated as beat L-1 (the penultimate) is sampled. The owner changes at the edge that samples beat L.
- R6: On single transfers and unspecified-length bursts, every ready-high beat is a re-arbitration point.
- R7: Response codes are 0 okay, 1 error, 2 retry, 3 split. For a RETRY, the block waits for the ready-high second cycle and then re-arbitrates with the retried master still eligible. That master is re-granted unless a lower-index master requests.
- R8: On the second cycle of a SPLIT, the master that owned the data phase becomes masked. A masked master is never granted, while other requesters may be granted.
- R9: A set bit in the split release vector unmasks that master at the next edge. The master then competes at its normal priority from the following arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | NUM_MASTERS | Request line per master |
| xfer_ready | input | 1 | Transfer-complete qualifier from the bus |
| slv_resp | input | 2 | Slave response code |
| xfer_kind | input | 2 | Transfer kind of the current address phase |
| burst_kind | input | 3 | Burst kind of the current address phase |
| split_clear | input | NUM_MASTERS | Per-master release of the split mask |
| bus_gnt | output | NUM_MASTERS | Grant line per master |
| owner_idx | output | IDX_W | Index of the address-phase owner |

## Verification
The bench builds the block with its defaults: four masters, a 4-bit owner index and master 0 as the parking master. This small size lets all sixteen request patterns be swept from the parked state, each with its expected grant and owner index computed in the bench. Fixed bursts of four, eight and sixteen beats are checked beat by beat against the penultimate-beat rule. Retries are run against competitors of both higher and lower priority. Split masking and release are exercised for an ordinary master and for the parking master itself.

// File: rtl/shbus_arb_pkg.sv
`timescale 1ns/1ps
package shbus_arb_pkg;

    localparam int MAX_BURST_BEATS = 16;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_BUSY   = 2'd1,
        XF_NONSEQ = 2'd2,
        XF_SEQ    = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'd0,
        RS_ERROR = 2'd1,
        RS_RETRY = 2'd2,
        RS_SPLIT = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        ST_OPEN,
        ST_MOVE,
        ST_BURST,
        ST_RESP
    } arb_st_e;

    // beats in a burst kind; 0 means length not defined
    function automatic logic [4:0] burst_beats(input logic [2:0] code);
        if (code[2:1] == 2'b00)
            return code[0] ? 5'd0 : 5'd1;
        return 5'd2 << code[2:1];
    endfunction

endpackage

// File: rtl/shbus_arb_pick.sv
`timescale 1ns/1ps
module shbus_arb_pick #(
    parameter int N  = 4,
    parameter int IW = 4
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/shbus_arb_split.sv
`timescale 1ns/1ps
module shbus_arb_split #(
    parameter int N  = 4,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic [N-1:0]  clear_vec,
    output logic [N-1:0]  mask
);

    logic [N-1:0] set_vec;
    logic [N-1:0] clr_only;

    assign set_vec  = set_en ? (N'(1) << set_idx) : '0;
    assign clr_only = clear_vec & ~set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else
            mask <= (mask & ~clear_vec) | set_vec;
    end

    // R9: a release bit not colliding with a new split leaves that bit clear
    p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_only) |=> ((mask & $past(clr_only)) == '0));

endmodule

// File: rtl/shbus_arb_ctrl.sv
`timescale 1ns/1ps
module shbus_arb_ctrl
    import shbus_arb_pkg::*;
#(
    parameter int MAX_BEATS = MAX_BURST_BEATS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic [1:0] resp,
    input  logic [1:0] xfer,
    input  logic [2:0] burst,
    input  logic       winner_moves,
    output logic       arb_go,
    output logic       split_now,
    output arb_st_e    state
);

    localparam int CNT_W = $clog2(MAX_BEATS);

    arb_st_e          st_q;
    arb_st_e          st_d;
    logic [CNT_W-1:0] left_q;
    logic             split_kind_q;
    logic [4:0]       blen;
    logic             nseq_fixed;
    logic             resp_hit;

    assign blen       = burst_beats(burst);
    assign nseq_fixed = (xfer == XF_NONSEQ) && (blen > 5'd1);
    assign resp_hit   = (resp == RS_RETRY) || (resp == RS_SPLIT);
    assign state      = st_q;

    // state register and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= ST_OPEN;
            left_q       <= '0;
            split_kind_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (!ready && resp_hit && st_q != ST_RESP)
                split_kind_q <= (resp == RS_SPLIT);
            if (ready && (st_q == ST_OPEN || st_q == ST_BURST)) begin
                if (nseq_fixed)
                    left_q <= CNT_W'(blen - 5'd1);
                else if (st_q == ST_BURST && xfer == XF_SEQ)
                    left_q <= left_q - 1'b1;
            end
        end
    end

    // outputs: when arbitration may run, and whether it follows a split
    always_comb begin
        arb_go    = 1'b0;
        split_now = 1'b0;
        if (ready) begin
            unique case (st_q)
                ST_RESP: begin
                    arb_go    = 1'b1;
                    split_now = split_kind_q;
                end
                ST_MOVE:  arb_go = 1'b0;
                ST_BURST: begin
                    if (xfer == XF_SEQ)
                        arb_go = (left_q <= CNT_W'(2));
                    else if (xfer == XF_BUSY)
                        arb_go = 1'b0;
                    else
                        arb_go = !nseq_fixed;
                end
                ST_OPEN:  arb_go = !nseq_fixed;
                default:  arb_go = 1'b0;
            endcase
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!ready) begin
            if (resp_hit && st_q != ST_RESP)
                st_d = ST_RESP;
        end else if (arb_go) begin
            st_d = winner_moves ? ST_MOVE : ST_OPEN;
        end else if (st_q == ST_MOVE) begin
            st_d = ST_OPEN;
        end else if (nseq_fixed) begin
            st_d = ST_BURST;
        end
    end

    // R7: the response state is only reached through a ready-low cycle
    p_resp_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESP) |-> !$past(ready));

    // R5: a held burst always has at least two beats still to come
    p_burst_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BURST) |-> (left_q >= CNT_W'(2)));

endmodule

// File: rtl/shbus_arbiter.sv
`timescale 1ns/1ps
module shbus_arbiter
    import shbus_arb_pkg::*;
#(
    parameter int NUM_MASTERS    = 4,
    parameter int IDX_W          = 4,
    parameter int DEFAULT_MASTER = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] bus_req,
    input  logic                   xfer_ready,
    input  logic [1:0]             slv_resp,
    input  logic [1:0]             xfer_kind,
    input  logic [2:0]             burst_kind,
    input  logic [NUM_MASTERS-1:0] split_clear,
    output logic [NUM_MASTERS-1:0] bus_gnt,
    output logic [IDX_W-1:0]       owner_idx
);

    localparam logic [IDX_W-1:0] DEF_IDX = IDX_W'(DEFAULT_MASTER);

    function automatic logic [NUM_MASTERS-1:0] onehot(input logic [IDX_W-1:0] i);
        return NUM_MASTERS'(1) << i;
    endfunction

    logic [IDX_W-1:0]       gidx_q;
    logic                   gnone_q;
    logic [IDX_W-1:0]       own_q;
    logic [IDX_W-1:0]       dwn_q;
    logic [NUM_MASTERS-1:0] split_mask;
    logic [NUM_MASTERS-1:0] elig;
    logic                   arb_go;
    logic                   split_now;
    arb_st_e                st;
    logic                   found_r;
    logic                   found_e;
    logic [IDX_W-1:0]       idx_r;
    logic [IDX_W-1:0]       idx_e;
    logic [IDX_W-1:0]       pick_idx;
    logic                   pick_none;
    logic                   winner_moves;

    assign elig = ~split_mask & ~(split_now ? onehot(dwn_q) : '0);

    shbus_arb_pick #(.N(NUM_MASTERS), .IW(IDX_W)) u_pick_req (
        .cand  (bus_req & elig),
        .found (found_r),
        .idx   (idx_r)
    );

    shbus_arb_pick #(.N(NUM_MASTERS), .IW(IDX_W)) u_pick_park (
        .cand  (elig),
        .found (found_e),
        .idx   (idx_e)
    );

    always_comb begin
        pick_none = 1'b0;
        if (found_r)
            pick_idx = idx_r;
        else if (elig[DEFAULT_MASTER])
            pick_idx = DEF_IDX;
        else if (found_e)
            pick_idx = idx_e;
        else begin
            pick_idx  = DEF_IDX;
            pick_none = 1'b1;
        end
    end

    assign winner_moves = (pick_idx != gidx_q) || (pick_none != gnone_q);

    shbus_arb_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready        (xfer_ready),
        .resp         (slv_resp),
        .xfer         (xfer_kind),
        .burst        (burst_kind),
        .winner_moves (winner_moves),
        .arb_go       (arb_go),
        .split_now    (split_now),
        .state        (st)
    );

    shbus_arb_split #(.N(NUM_MASTERS), .IW(IDX_W)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (split_now),
        .set_idx   (dwn_q),
        .clear_vec (split_clear),
        .mask      (split_mask)
    );

    // grant, address-phase owner and data-phase owner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gidx_q  <= DEF_IDX;
            gnone_q <= 1'b0;
            own_q   <= DEF_IDX;
            dwn_q   <= DEF_IDX;
        end else if (xfer_ready) begin
            own_q <= gidx_q;
            dwn_q <= own_q;
            if (arb_go) begin
                gidx_q  <= pick_idx;
                gnone_q <= pick_none;
            end
        end
    end

    assign bus_gnt   = gnone_q ? '0 : onehot(gidx_q);
    assign owner_idx = own_q;

    // R3: nothing visible moves while ready is low
    p_hold_no_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_ready |=> ($stable(bus_gnt) && $stable(owner_idx)));

    // R8: a split-masked master never holds the grant
    p_no_masked_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt & split_mask) == '0);

    // R4: in the open state the owner is the granted master
    p_open_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPEN && !gnone_q) |-> ((bus_gnt & onehot(own_q)) != '0));

endmodule

// File: tb/sim_shbus_arbiter.sv
`timescale 1ns/1ps
module sim_shbus_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req;
    logic       rdy;
    logic [1:0] resp;
    logic [1:0] xk;
    logic [2:0] bk;
    logic [3:0] rel;
    logic [3:0] gnt;
    logic [3:0] own;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    shbus_arbiter u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (req),
        .xfer_ready  (rdy),
        .slv_resp    (resp),
        .xfer_kind   (xk),
        .burst_kind  (bk),
        .split_clear (rel),
        .bus_gnt     (gnt),
        .owner_idx   (own)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] prio_exp(input logic [3:0] r);
        for (int i = 0; i < 4; i++)
            if (r[i]) return 4'(1 << i);
        return 4'b0001;
    endfunction

    function automatic logic [3:0] idx_of(input logic [3:0] g);
        for (int i = 0; i < 4; i++)
            if (g[i]) return 4'(i);
        return 4'd0;
    endfunction

    // three ready ticks with idle transfers settle the owner on the winner of r
    task automatic settle(input logic [3:0] r, input logic [3:0] exp_own);
        req = r; xk = 2'd0; bk = 3'd0; rdy = 1'b1; resp = 2'd0;
        tick(); tick(); tick();
        chk("R4 settle owner", 32'(own), 32'(exp_own));
    endtask

    task automatic retry_case(input logic [3:0] comp, input logic [3:0] exp);
        settle(4'b0100, 4'd2);
        xk = 2'd2; bk = 3'd0; tick();
        xk = 2'd0; rdy = 1'b0; resp = 2'd2; req = comp; tick();
        chk("R7 retry first cycle holds", 32'(gnt), 32'h4);
        rdy = 1'b1; tick();
        chk("R7 retry grant", 32'(gnt), 32'(exp));
        resp = 2'd0;
    endtask

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; rdy = 1'b1; resp = 2'd0; xk = 2'd0; bk = 3'd0; rel = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk("R2 reset grant", 32'(gnt), 32'h1);
        chk("R4 reset owner", 32'(own), 32'h0);

        // R1 / R2: sweep every request pattern from the parked state
        for (int p = 0; p < 16; p++) begin
            req = 4'(p);
            tick();
            chk("R1 sweep grant", 32'(gnt), 32'(prio_exp(4'(p))));
            tick();
            chk("R4 sweep owner", 32'(own), 32'(idx_of(prio_exp(4'(p)))));
            req = '0;
            tick(); tick();
        end

        // R3: ready low freezes grant and owner
        req = 4'b0100; rdy = 1'b0;
        tick(); tick(); tick();
        chk("R3 grant frozen", 32'(gnt), 32'h1);
        rdy = 1'b1; tick();
        chk("R3 grant after ready", 32'(gnt), 32'h4);
        chk("R4 owner lags grant", 32'(own), 32'h0);
        rdy = 1'b0; tick();
        chk("R3 owner frozen", 32'(own), 32'h0);
        rdy = 1'b1; tick();
        chk("R4 owner follows", 32'(own), 32'h2);

        // R6: unspecified-length burst is overtaken mid-burst
        xk = 2'd2; bk = 3'd1; tick();
        chk("R6 first beat keeps grant", 32'(gnt), 32'h4);
        xk = 2'd3; req = 4'b0110; tick();
        chk("R6 overtaken on sequential beat", 32'(gnt), 32'h2);
        xk = 2'd0; tick();
        chk("R6 owner moves", 32'(own), 32'h1);

        // R5: fixed bursts of 4, 8, 16 beats, handover at penultimate beat
        for (int li = 0; li < 3; li++) begin
            int blen;
            blen = 4 << li;
            settle(4'b0010, 4'd1);
            req = 4'b0011; xk = 2'd2; bk = 3'((li + 1) * 2 + (li & 1));
            for (int k = 0; k < blen; k++) begin
                if (k > 0) xk = 2'd3;
                tick();
                chk("R5 burst grant", 32'(gnt), (k >= blen - 2) ? 32'h1 : 32'h2);
                chk("R5 burst owner", 32'(own), (k >= blen - 1) ? 32'h0 : 32'h1);
            end
            xk = 2'd0; bk = 3'd0;
        end

        // R7: retry with various competitors
        retry_case(4'b0100, 4'b0100);
        retry_case(4'b1100, 4'b0100);
        retry_case(4'b0110, 4'b0010);
        retry_case(4'b0101, 4'b0001);

        // R8 / R9: split master 2, mask, then release
        settle(4'b0100, 4'd2);
        xk = 2'd2; bk = 3'd0; tick();
        xk = 2'd0; rdy = 1'b0; resp = 2'd3; tick();
        rdy = 1'b1; tick();
        chk("R8 split parks on master 0", 32'(gnt), 32'h1);
        resp = 2'd0;
        for (int k = 0; k < 6; k++) begin
            tick();
            chk("R8 split master not granted", 32'(gnt & 4'b0100), 32'h0);
        end
        req = 4'b1100; tick();
        chk("R8 other master granted", 32'(gnt), 32'h8);
        tick();
        chk("R8 owner 3", 32'(own), 32'h3);
        rel = 4'b0100; tick();
        chk("R9 release edge keeps grant", 32'(gnt), 32'h8);
        rel = '0; tick();
        chk("R9 released master regranted", 32'(gnt), 32'h4);
        tick();
        chk("R9 released master owns", 32'(own), 32'h2);

        // R2 / R8 / R9: split the parking master itself
        settle(4'b0001, 4'd0);
        xk = 2'd2; bk = 3'd0; tick();
        xk = 2'd0; rdy = 1'b0; resp = 2'd3; req = 4'b0000; tick();
        rdy = 1'b1; tick();
        chk("R2 park on lowest unmasked", 32'(gnt), 32'h2);
        resp = 2'd0; req = 4'b0001;
        tick(); tick();
        chk("R8 masked master 0 not granted", 32'(gnt), 32'h2);
        rel = 4'b0001; tick();
        rel = '0; tick();
        chk("R9 master 0 regranted", 32'(gnt), 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule